// File: doc/BRIEF.md
# Byte-Lane Strobe Decoder

This block turns the low address bits, transfer size and direction of a 32-bit processor bus cycle into four active-low byte-lane strobes for a 32-bit memory port. The bus supports dynamic sizing, so a transfer may start at any byte offset and carry one, two, three or four bytes. On a write, only the lanes that the transfer actually covers are enabled. On a read, every lane is enabled and the processor picks out the bytes it needs.

Two strobe groups are produced. The direct group depends only on the transfer. The mapped group carries the same lanes, gated by two conditions: a match of a slice of high address bits against a fixed bank value, and the absence of a CPU-space cycle, which is flagged when every function-code bit is 1. With the default four-bit slice wired to address bits 21 down to 18, the bank covers 256 KB.

The strobes are registered. On every clock edge the decoder samples the address strobe together with the transfer fields and updates its outputs.

Top module: `lane_strobe_decoder`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, both strobe groups are driven to 4'b1111 after that edge.
- R2: When `as_n` is sampled low with `rw` = 1 (read), all four direct lanes assert (4'b0000) for every offset and size. The mapped lanes also all assert when the bank matches and the cycle is not CPU space.
- R3: On a write, lane bit 3 (D31–D24) asserts only when `addr_off` = 00, for any size. Size codes are 00 = four bytes, 01 = one byte, 10 = two bytes, 11 = three bytes.
- R4: On a write, lane bit 2 (D23–D16) asserts at offset 01 for any size, and at offset 00 for any size other than one byte (size codes as in R3).
- R5: On a write, lane bit 1 (D15–D8) asserts at offset 10 for any size, at offset 01 for two, three or four bytes, and at offset 00 for three or four bytes (size codes as in R3).
- R6: On a write, lane bit 0 (D7–D0) asserts at offset 11 for any size, at offset 10 for two or three bytes, at offset 01 for three bytes, and at any offset for four bytes (size codes as in R3).
- R7: The direct group ignores `addr_bank` and `fc`. A mapped lane asserts only if the same direct lane asserts.
- R8: When all `fc` bits are 1 (CPU space), the mapped group stays at 4'b1111. Any other `fc` value leaves it equal to the direct group when the bank matches.
- R9: When `addr_bank` differs from `BANK_MATCH`, the mapped group stays at 4'b1111.
- R10: Outputs reflect the inputs sampled at the rising edge where `as_n` is low. At the edge where `as_n` is sampled high, both groups return to 4'b1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| fc | input | FC_W | Function code of the cycle |
| addr_off | input | 2 | Byte offset within the long word (A1:A0) |
| size | input | 2 | Transfer size code |
| addr_bank | input | BANK_W | High address slice used for bank decode |
| direct_n | output | 4 | Unqualified lane strobes, active low, bit 3 = D31–D24 |
| mapped_n | output | 4 | Bank- and space-qualified lane strobes, active low |

## Verification
The hardest situation to reach is a misaligned multi-byte write whose end runs past the last lane, such as a long-word write at offset 3. The strobes must then clip at D7–D0 rather than wrap. The same cases must also be separated from reads and from the mapped-group gating. The bench reaches these by sweeping every offset and size pair for writes, in and out of the bank and in and out of CPU space. It compares each lane with a reference built from the byte range the transfer covers, and it also steps the address strobe to confirm which edge the strobes follow.

// File: rtl/lane_sel_pkg.sv
// Package: shared types for the byte-lane strobe decoder.
// Assumes a 32-bit port split into four byte lanes; lane index 3 carries
// D31-D24 and lane index 0 carries D7-D0.
package lane_sel_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        SZ_LONG   = 2'b00,
        SZ_BYTE   = 2'b01,
        SZ_WORD   = 2'b10,
        SZ_TRIPLE = 2'b11
    } xfer_size_e;

    typedef logic [LANES-1:0] lane_vec_t;

endpackage

// File: rtl/lane_write_decode.sv
// Module: lane_write_decode
// Purpose: combinational decode of the lanes a transfer touches, active high.
// Assumes: offset is A1:A0, size uses xfer_size_e, rw = 1 means read.
// A read enables every lane. A write enables only the lanes from the offset up
// to the end of the transfer, clipped at the last lane of the port.
module lane_write_decode
    import lane_sel_pkg::*;
(
    input  logic       rd,
    input  logic [1:0] offset,
    input  xfer_size_e size,
    output lane_vec_t  lanes
);

    logic a0, a1;
    logic is_byte, is_word, is_triple, is_long;

    // Split the inputs into single-bit terms for the product terms below.
    always_comb begin
        a0        = offset[0];
        a1        = offset[1];
        is_byte   = (size == SZ_BYTE);
        is_word   = (size == SZ_WORD);
        is_triple = (size == SZ_TRIPLE);
        is_long   = (size == SZ_LONG);
    end

    // Sum-of-products for each lane, with the read term covering every lane.
    always_comb begin
        lanes[3] = rd | (!a1 & !a0);
        lanes[2] = rd | (!a1 & a0) | (!a1 & !a0 & !is_byte);
        lanes[1] = rd | (a1 & !a0)
                      | (!a1 & a0 & !is_byte)
                      | (!a1 & !a0 & (is_long | is_triple));
        lanes[0] = rd | (a1 & a0)
                      | (a1 & !a0 & (is_word | is_triple))
                      | (!a1 & a0 & is_triple)
                      | is_long;
    end

endmodule

// File: rtl/bank_qualifier.sv
// Module: bank_qualifier
// Purpose: decides whether the mapped lane group may assert in this cycle.
// Assumes: bank_addr is the high address slice chosen at integration, and a
// CPU-space cycle is one whose function-code bits are all 1.
module bank_qualifier #(
    parameter int                FC_W       = 3,
    parameter int                BANK_W     = 4,
    parameter logic [BANK_W-1:0] BANK_MATCH = 4'h3
) (
    input  logic [FC_W-1:0]   fc,
    input  logic [BANK_W-1:0] bank_addr,
    output logic              enable
);

    logic bank_hit;
    logic not_cpu_space;

    // Bank compare and the NAND of the function code, combined into one enable.
    always_comb begin
        bank_hit      = (bank_addr == BANK_MATCH);
        not_cpu_space = ~(&fc);
        enable        = bank_hit & not_cpu_space;
    end

endmodule

// File: rtl/lane_strobe_reg.sv
// Module: lane_strobe_reg
// Purpose: output register stage that turns active-high lane enables into
// active-low strobes qualified by the address strobe.
// Assumes: synchronous active-low reset; all strobes idle high.
module lane_strobe_reg #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_n,
    input  logic [LANES-1:0] direct_en,
    input  logic [LANES-1:0] mapped_en,
    output logic [LANES-1:0] direct_n,
    output logic [LANES-1:0] mapped_n
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One flop pair per lane: idle high, low while the strobe and the enable are both active.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                direct_n[g] <= 1'b1;
                mapped_n[g] <= 1'b1;
            end else begin
                direct_n[g] <= as_n | ~direct_en[g];
                mapped_n[g] <= as_n | ~mapped_en[g];
            end
        end
    end

endmodule

// File: rtl/lane_strobe_decoder.sv
// Module: lane_strobe_decoder (top)
// Purpose: registered byte-lane strobes for a 32-bit memory port on a bus with
// dynamic sizing. It has a direct group and a mapped group; the mapped group is
// gated by a bank match and by the absence of a CPU-space cycle.
// Assumes: addr_bank is wired to the address slice chosen for the bank
// (A21..A18 gives a 256 KB bank); strobes follow inputs sampled at each edge.
module lane_strobe_decoder
    import lane_sel_pkg::*;
#(
    parameter int                FC_W       = 3,
    parameter int                BANK_W     = 4,
    parameter logic [BANK_W-1:0] BANK_MATCH = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              rw,
    input  logic [FC_W-1:0]   fc,
    input  logic [1:0]        addr_off,
    input  logic [1:0]        size,
    input  logic [BANK_W-1:0] addr_bank,
    output logic [3:0]        direct_n,
    output logic [3:0]        mapped_n
);

    lane_vec_t lanes;
    lane_vec_t mapped_lanes;
    logic      map_enable;

    lane_write_decode u_decode (
        .rd     (rw),
        .offset (addr_off),
        .size   (xfer_size_e'(size)),
        .lanes  (lanes)
    );

    bank_qualifier #(
        .FC_W       (FC_W),
        .BANK_W     (BANK_W),
        .BANK_MATCH (BANK_MATCH)
    ) u_qual (
        .fc        (fc),
        .bank_addr (addr_bank),
        .enable    (map_enable)
    );

    // Mapped lanes are the direct lanes masked by the bank/space enable.
    always_comb begin
        mapped_lanes = lanes & {LANES{map_enable}};
    end

    lane_strobe_reg #(
        .LANES (LANES)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n      (as_n),
        .direct_en (lanes),
        .mapped_en (mapped_lanes),
        .direct_n  (direct_n),
        .mapped_n  (mapped_n)
    );

endmodule

// File: rtl/lane_strobe_checker.sv
// Module: lane_strobe_checker
// Purpose: temporal properties on the ports of lane_strobe_decoder, bound below.
// Assumes the same parameters as the decoder it is bound to.
module lane_strobe_checker #(
    parameter int                FC_W       = 3,
    parameter int                BANK_W     = 4,
    parameter logic [BANK_W-1:0] BANK_MATCH = 4'h3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              as_n,
    input logic              rw,
    input logic [FC_W-1:0]   fc,
    input logic [1:0]        addr_off,
    input logic [1:0]        size,
    input logic [BANK_W-1:0] addr_bank,
    input logic [3:0]        direct_n,
    input logic [3:0]        mapped_n
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (direct_n == 4'hF && mapped_n == 4'hF)); // R1

    AST_READ_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && rw) |=> (direct_n == 4'h0)); // R2

    AST_UPPER_ALIGNED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !rw && addr_off != 2'b00) |=> direct_n[3]); // R3

    AST_LONG_REACHES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !rw && size == 2'b00) |=> !direct_n[0]); // R6

    AST_MAPPED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(!rst_n) |-> ((~mapped_n & direct_n) == 4'h0)); // R7

    AST_CPU_SPACE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (&fc) |=> (mapped_n == 4'hF)); // R8

    AST_BANK_MISS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_bank != BANK_MATCH) |=> (mapped_n == 4'hF)); // R9

    AST_IDLE_WHEN_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> (direct_n == 4'hF && mapped_n == 4'hF)); // R10

endmodule

bind lane_strobe_decoder lane_strobe_checker #(
    .FC_W       (FC_W),
    .BANK_W     (BANK_W),
    .BANK_MATCH (BANK_MATCH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .as_n      (as_n),
    .rw        (rw),
    .fc        (fc),
    .addr_off  (addr_off),
    .size      (size),
    .addr_bank (addr_bank),
    .direct_n  (direct_n),
    .mapped_n  (mapped_n)
);

// File: tb/lane_strobe_decoder_bench.sv
`timescale 1ns/1ps
module lane_strobe_decoder_bench;

    localparam logic [3:0] HIT  = 4'h3;
    localparam logic [3:0] MISS = 4'h5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       as_n = 1'b1;
    logic       rw = 1'b1;
    logic [2:0] fc = 3'b001;
    logic [1:0] addr_off = 2'b00;
    logic [1:0] size = 2'b00;
    logic [3:0] addr_bank = HIT;
    logic [3:0] direct_n;
    logic [3:0] mapped_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lane_strobe_decoder u_lane_strobe_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n      (as_n),
        .rw        (rw),
        .fc        (fc),
        .addr_off  (addr_off),
        .size      (size),
        .addr_bank (addr_bank),
        .direct_n  (direct_n),
        .mapped_n  (mapped_n)
    );

    // Reference: active-high lanes covered by the transfer; bit 3 = byte offset 0.
    function automatic logic [3:0] ref_lanes(input logic rd, input logic [1:0] off,
                                             input logic [1:0] sz);
        int n;
        logic [3:0] v;
        n = (sz == 2'b00) ? 4 : (sz == 2'b01) ? 1 : (sz == 2'b10) ? 2 : 3;
        for (int b = 0; b < 4; b++)
            v[3-b] = rd || (b >= int'(off) && b < int'(off) + n);
        return v;
    endfunction

    task automatic check_vec(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, then sample at the next falling edge.
    task automatic step(input logic s_n, input logic r, input logic [2:0] f,
                        input logic [1:0] o, input logic [1:0] z, input logic [3:0] b);
        @(negedge clk);
        as_n = s_n; rw = r; fc = f; addr_off = o; size = z; addr_bank = b;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(1'b0, 1'b1, 3'b001, 2'b00, 2'b00, HIT);
        check_vec("R1 direct in reset", direct_n, 4'hF);
        check_vec("R1 mapped in reset", mapped_n, 4'hF);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b1, 3'b001, 2'b00, 2'b00, HIT);
    endtask

    task automatic t_read_sweep();
        for (int o = 0; o < 4; o++)
            for (int z = 0; z < 4; z++) begin
                step(1'b0, 1'b1, 3'b101, 2'(o), 2'(z), HIT);
                check_vec("R2 read direct", direct_n, 4'h0);
                check_vec("R2 read mapped", mapped_n, 4'h0);
            end
    endtask

    task automatic t_write_sweep();
        for (int o = 0; o < 4; o++)
            for (int z = 0; z < 4; z++) begin
                logic [3:0] e;
                e = ~ref_lanes(1'b0, 2'(o), 2'(z));
                step(1'b0, 1'b0, 3'b001, 2'(o), 2'(z), HIT);
                check_bit("R3 lane D31-D24", direct_n[3], e[3]);
                check_bit("R4 lane D23-D16", direct_n[2], e[2]);
                check_bit("R5 lane D15-D8",  direct_n[1], e[1]);
                check_bit("R6 lane D7-D0",   direct_n[0], e[0]);
                check_vec("R7 mapped equals direct in bank", mapped_n, e);
            end
    endtask

    task automatic t_bank_miss();
        for (int r = 0; r < 2; r++)
            for (int o = 0; o < 4; o++)
                for (int z = 0; z < 4; z++) begin
                    step(1'b0, 1'(r), 3'b010, 2'(o), 2'(z), MISS);
                    check_vec("R9 mapped on bank miss", mapped_n, 4'hF);
                    check_vec("R7 direct ignores bank", direct_n,
                              ~ref_lanes(1'(r), 2'(o), 2'(z)));
                end
    endtask

    task automatic t_cpu_space();
        for (int r = 0; r < 2; r++)
            for (int o = 0; o < 4; o++)
                for (int z = 0; z < 4; z++) begin
                    step(1'b0, 1'(r), 3'b111, 2'(o), 2'(z), HIT);
                    check_vec("R8 mapped in CPU space", mapped_n, 4'hF);
                    check_vec("R7 direct ignores fc", direct_n,
                              ~ref_lanes(1'(r), 2'(o), 2'(z)));
                end
        for (int f = 0; f < 7; f++) begin
            step(1'b0, 1'b0, 3'(f), 2'b01, 2'b10, HIT);
            check_vec("R8 mapped outside CPU space", mapped_n, 4'b1001);
        end
    endtask

    task automatic t_timing();
        step(1'b1, 1'b1, 3'b001, 2'b00, 2'b00, HIT);
        check_vec("R10 idle with strobe high", direct_n, 4'hF);
        check_vec("R10 mapped idle with strobe high", mapped_n, 4'hF);
        @(negedge clk);
        as_n = 1'b0; rw = 1'b0; addr_off = 2'b11; size = 2'b00;
        #1;
        check_vec("R10 no change before edge", direct_n, 4'hF);
        @(negedge clk);
        check_vec("R10 asserts after edge", direct_n, 4'b1110);
        addr_off = 2'b00; size = 2'b10;
        @(negedge clk);
        check_vec("R10 follows new sample", direct_n, 4'b0011);
        as_n = 1'b1;
        @(negedge clk);
        check_vec("R10 release direct", direct_n, 4'hF);
        check_vec("R10 release mapped", mapped_n, 4'hF);
    endtask

    initial begin
        t_reset();
        t_read_sweep();
        t_write_sweep();
        t_bank_miss();
        t_cpu_space();
        t_timing();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule